// File: doc/BRIEF.md
# Output Range Clamp

This block sits at the end of a pixel pipeline and holds each of the three 12-bit colour components (R/Cr, G/Y, B/Cb) inside a chosen window before the pixels go to a display link. A 3-bit format code picks the window. Three codes select fixed limited-range windows for 8, 10 and 12 bits per channel. A fourth code selects a programmable window with its own lower and upper bound for each channel. Every other setting passes the data through unchanged. A master enable must also be high before any clamping happens.

Pixels enter and leave on valid/ready streams through a single register stage. A pixel moves on the input side when `in_valid` and `in_ready` are both high at a clock edge. A pixel moves on the output side when `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so the block sustains one pixel per clock when downstream does not stall. When `out_ready` is low while `out_valid` is high, the held pixel and its valid do not change, and `in_ready` goes low.

The configuration pins (`clamp_en`, `fmt_sel` and the six bounds) are plain levels. They are sampled together with each pixel at the moment that pixel is accepted. The usual tie-off for a programmable window is 0x010 for each lower bound and 0xFEF for each upper bound.

Top module: `pix_range_clamp`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: While `clamp_en` is 0, every component is passed through unchanged, whatever the value of `fmt_sel`.
- R3: With `clamp_en` at 1, format code 0 (full range) and the unused codes 4, 5 and 6 all pass every component through unchanged.
- R4: With `clamp_en` at 1, codes 1, 2 and 3 select the 8-, 10- and 12-bit limited ranges (16..235, 64..940 and 256..3760), each shifted to the top of the 12-bit bus. All three therefore become the window 256..3760 on this bus.
- R5: With `clamp_en` at 1, code 7 clamps each channel to its own pair of bounds (`lo_r`/`hi_r`, `lo_g`/`hi_g`, `lo_b`/`hi_b`), and each channel is independent of the others.
- R6: When clamping is active, a value below the lower bound becomes the lower bound and a value above the upper bound becomes the upper bound. A value between them, or equal to either bound, passes unchanged.
- R7: If a programmable lower bound is greater than its upper bound, the lower-bound test wins. Any value below the lower bound leaves as the lower bound, and every other value leaves as the upper bound.
- R8: A pixel accepted at clock edge N is presented with `out_valid` high just after edge N, and pixels leave in the order they were accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output components and `out_valid` stay unchanged and `in_ready` is 0.
- R10: The configuration is captured with each pixel when it is accepted. A change on the configuration pins after acceptance does not alter a pixel already held in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_r | input | 12 | R/Cr component in |
| in_g | input | 12 | G/Y component in |
| in_b | input | 12 | B/Cb component in |
| clamp_en | input | 1 | Master clamp enable |
| fmt_sel | input | 3 | Window select: 0 full, 1/2/3 limited 8/10/12 bit, 7 programmable |
| lo_r | input | 12 | Programmable lower bound, R/Cr |
| lo_g | input | 12 | Programmable lower bound, G/Y |
| lo_b | input | 12 | Programmable lower bound, B/Cb |
| hi_r | input | 12 | Programmable upper bound, R/Cr |
| hi_g | input | 12 | Programmable upper bound, G/Y |
| hi_b | input | 12 | Programmable upper bound, B/Cb |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_r | output | 12 | Clamped R/Cr component |
| out_g | output | 12 | Clamped G/Y component |
| out_b | output | 12 | Clamped B/Cb component |

## Verification
Two events can fall in the same cycle: a configuration change and a stall that holds a pixel clamped under the previous settings in the output register. The bench provokes this by stopping `out_ready`, sending a pixel under a programmable window, and then changing the enable, the code and the bounds while that pixel waits. The held components must stay bit-for-bit constant, and the pixel must leave with the value the scoreboard computed from the settings in force when it was accepted. Separately, a repeating ready pattern produces simultaneous input and output handshakes, which tests ordering and the one-stage latency.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;

  typedef enum logic [2:0] {
    WIN_FULL   = 3'd0,
    WIN_LIM8   = 3'd1,
    WIN_LIM10  = 3'd2,
    WIN_LIM12  = 3'd3,
    WIN_PROG   = 3'd7
  } win_code_e;

  localparam int NUM_CH = 3;

  // Limited-range floor for a native depth, aligned to the top of a cw-bit bus.
  function automatic int preset_floor(input int bits, input int cw);
    return (16 << (bits - 8)) << (cw - bits);
  endfunction

  // Limited-range ceiling for a native depth, aligned to the top of a cw-bit bus.
  function automatic int preset_ceil(input int bits, input int cw);
    return (235 << (bits - 8)) << (cw - bits);
  endfunction

endpackage

// File: rtl/clamp_limit_sel.sv
module clamp_limit_sel
  import pix_clamp_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                     en,
  input  logic [2:0]               code,
  input  logic [NUM_CH-1:0][CW-1:0] prog_lo,
  input  logic [NUM_CH-1:0][CW-1:0] prog_hi,
  output logic                     active,
  output logic [NUM_CH-1:0][CW-1:0] lim_lo,
  output logic [NUM_CH-1:0][CW-1:0] lim_hi
);

  localparam logic [CW-1:0] L8_LO  = CW'(preset_floor(8,  CW));
  localparam logic [CW-1:0] L8_HI  = CW'(preset_ceil (8,  CW));
  localparam logic [CW-1:0] L10_LO = CW'(preset_floor(10, CW));
  localparam logic [CW-1:0] L10_HI = CW'(preset_ceil (10, CW));
  localparam logic [CW-1:0] L12_LO = CW'(preset_floor(12, CW));
  localparam logic [CW-1:0] L12_HI = CW'(preset_ceil (12, CW));

  win_code_e win;
  assign win = win_code_e'(code);

  always_comb begin
    active = 1'b0;
    lim_lo = '0;
    lim_hi = '1;
    if (en) begin
      case (win)
        WIN_LIM8: begin
          active = 1'b1;
          lim_lo = {NUM_CH{L8_LO}};
          lim_hi = {NUM_CH{L8_HI}};
        end
        WIN_LIM10: begin
          active = 1'b1;
          lim_lo = {NUM_CH{L10_LO}};
          lim_hi = {NUM_CH{L10_HI}};
        end
        WIN_LIM12: begin
          active = 1'b1;
          lim_lo = {NUM_CH{L12_LO}};
          lim_hi = {NUM_CH{L12_HI}};
        end
        WIN_PROG: begin
          active = 1'b1;
          lim_lo = prog_lo;
          lim_hi = prog_hi;
        end
        default: begin
          active = 1'b0;
        end
      endcase
    end
  end

  // Fixed windows are always well ordered.
  always_comb begin
    if (active && code != 3'd7) begin
      AST_PRESET_ORDERED: assert (lim_lo[0] < lim_hi[0]); // R4
    end
    if (!en) begin
      AST_DISABLED_IDLE: assert (!active); // R2
    end
  end

endmodule

// File: rtl/clamp_chan.sv
module clamp_chan #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] x,
  input  logic          active,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] y
);

  logic below, above;
  assign below = x < lo;
  assign above = x > hi;

  // Lower-bound test has priority over the upper-bound test.
  always_comb begin
    if (!active)    y = x;
    else if (below) y = lo;
    else if (above) y = hi;
    else            y = x;
  end

  always_comb begin
    if (active && (lo <= hi)) begin
      AST_IN_WINDOW: assert (y >= lo && y <= hi); // R6
    end
    if (active && (lo > hi) && (x >= lo)) begin
      AST_INVERTED_HI: assert (y == hi); // R7
    end
  end

endmodule

// File: rtl/clamp_out_stage.sv
module clamp_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);

  logic take;
  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (take) begin
        m_valid <= 1'b1;
        m_data  <= s_data;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (m_valid && m_data == $past(s_data))); // R8

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_valid && s_ready)); // R1

endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
  import pix_clamp_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic          clamp_en,
  input  logic [2:0]    fmt_sel,
  input  logic [CW-1:0] lo_r,
  input  logic [CW-1:0] lo_g,
  input  logic [CW-1:0] lo_b,
  input  logic [CW-1:0] hi_r,
  input  logic [CW-1:0] hi_g,
  input  logic [CW-1:0] hi_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);

  localparam int DW = NUM_CH * CW;

  logic [NUM_CH-1:0][CW-1:0] pix_in, pix_clamped, pix_out;
  logic [NUM_CH-1:0][CW-1:0] prog_lo, prog_hi, lim_lo, lim_hi;
  logic                      win_active;

  assign pix_in  = {in_b, in_g, in_r};
  assign prog_lo = {lo_b, lo_g, lo_r};
  assign prog_hi = {hi_b, hi_g, hi_r};

  clamp_limit_sel #(.CW(CW)) u_sel (
    .en      (clamp_en),
    .code    (fmt_sel),
    .prog_lo (prog_lo),
    .prog_hi (prog_hi),
    .active  (win_active),
    .lim_lo  (lim_lo),
    .lim_hi  (lim_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    clamp_chan #(.CW(CW)) u_chan (
      .x      (pix_in[c]),
      .active (win_active),
      .lo     (lim_lo[c]),
      .hi     (lim_hi[c]),
      .y      (pix_clamped[c])
    );
  end

  clamp_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pix_clamped),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pix_out)
  );

  assign out_r = pix_out[0];
  assign out_g = pix_out[1];
  assign out_b = pix_out[2];

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !clamp_en) |=> (pix_out == $past(pix_in))); // R2

endmodule

// File: tb/pix_range_clamp_tb_top.sv
module pix_range_clamp_tb_top;

  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0, in_ready;
  logic [CW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic          clamp_en = 1'b0;
  logic [2:0]    fmt_sel = 3'd0;
  logic [CW-1:0] lo_r = '0, lo_g = '0, lo_b = '0;
  logic [CW-1:0] hi_r = '1, hi_g = '1, hi_b = '1;
  logic          out_valid, out_ready = 1'b1;
  logic [CW-1:0] out_r, out_g, out_b;

  pix_range_clamp #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .clamp_en(clamp_en), .fmt_sel(fmt_sel),
    .lo_r(lo_r), .lo_g(lo_g), .lo_b(lo_b),
    .hi_r(hi_r), .hi_g(hi_g), .hi_b(hi_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;   // 0 always ready, 1 stalled, 2 pattern
  int cyc = 0;
  logic [3*CW-1:0] exp_q[$];
  string           tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [CW-1:0] model(input logic [CW-1:0] x, input logic en,
                                          input logic [2:0] code,
                                          input logic [CW-1:0] plo, input logic [CW-1:0] phi);
    logic [CW-1:0] l, h;
    if (!en) return x;
    case (code)
      3'd1, 3'd2, 3'd3: begin l = 12'd256; h = 12'd3760; end
      3'd7:             begin l = plo;     h = phi;      end
      default: return x;
    endcase
    if (x < l) return l;
    if (x > h) return h;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3*CW-1:0] act,
                       input logic [3*CW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [2:0] code,
                         input logic [CW-1:0] l0, l1, l2, h0, h1, h2);
    clamp_en = en; fmt_sel = code;
    lo_r = l0; lo_g = l1; lo_b = l2;
    hi_r = h0; hi_g = h1; hi_b = h2;
  endtask

  // Driver: offers one pixel, pushes its expected value when accepted.
  task automatic send(input logic [CW-1:0] r, g, b, input string req);
    @(negedge clk);
    in_r = r; in_g = g; in_b = b; in_valid = 1'b1;
    forever begin
      #2;
      if (in_ready) begin
        exp_q.push_back({model(b, clamp_en, fmt_sel, lo_b, hi_b),
                         model(g, clamp_en, fmt_sel, lo_g, hi_g),
                         model(r, clamp_en, fmt_sel, lo_r, hi_r)});
        tag_q.push_back(req);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: drives ready, pops and compares on each output handshake.
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'b0;
        default: out_ready = (cyc % 3) != 0;
      endcase
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected output", {out_b, out_g, out_r}, '0);
        end else begin
          logic [3*CW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_b, out_g, out_r} == e, t, {out_b, out_g, out_r}, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check(!out_valid, "R1 out_valid after reset", {35'd0, out_valid}, '0);
    check(in_ready, "R1 in_ready after reset", {35'd0, in_ready}, 36'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R1 idle after release", {34'd0, out_valid, in_ready}, 36'd1);

    // R2: disabled passes everything whatever the code
    set_cfg(1'b0, 3'd1, 12'd100, 12'd100, 12'd100, 12'd200, 12'd200, 12'd200);
    send(12'h000, 12'hFFF, 12'h123, "R2 disabled code1");
    fmt_sel = 3'd7;
    send(12'h005, 12'hFF0, 12'h800, "R2 disabled code7");

    // R3: full range and unused codes bypass
    for (int k = 0; k < 7; k++) begin
      if (k == 0 || k >= 4) begin
        set_cfg(1'b1, 3'(k), 12'd900, 12'd900, 12'd900, 12'd901, 12'd901, 12'd901);
        send(12'h001, 12'hFFE, 12'h0AB, "R3 bypass code");
      end
    end

    // R4: presets, below / above / inside
    for (int k = 1; k <= 3; k++) begin
      set_cfg(1'b1, 3'(k), 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0);
      send(12'd0, 12'hFFF, 12'd1000, "R4 preset window");
      send(12'd255, 12'd3761, 12'd256, "R4 preset edges");
    end

    // R5 / R6: programmable independent bounds, defaults and exact edges
    set_cfg(1'b1, 3'd7, 12'h010, 12'h010, 12'h010, 12'hFEF, 12'hFEF, 12'hFEF);
    send(12'h000, 12'hFFF, 12'h500, "R5 default bounds");
    set_cfg(1'b1, 3'd7, 12'd100, 12'd1000, 12'd2000, 12'd200, 12'd1500, 12'd3000);
    send(12'd50, 12'd50, 12'd50, "R5 per-channel low");
    send(12'd4000, 12'd4000, 12'd4000, "R5 per-channel high");
    send(12'd100, 12'd1500, 12'd2500, "R6 exact edges pass");
    send(12'd200, 12'd1000, 12'd2000, "R6 exact edges pass");
    send(12'd150, 12'd1200, 12'd2999, "R6 inside pass");

    // R7: inverted window, lower wins
    set_cfg(1'b1, 3'd7, 12'd500, 12'd500, 12'd500, 12'd300, 12'd300, 12'd300);
    send(12'd100, 12'd400, 12'd600, "R7 inverted window");

    // R8: back-to-back with a ready pattern (simultaneous in/out handshakes)
    ready_mode = 2;
    set_cfg(1'b1, 3'd2, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0);
    for (int k = 0; k < 12; k++) begin
      send(12'(k * 350), 12'(4095 - k * 300), 12'(k * 37), "R8 ordered stream");
    end
    ready_mode = 0;
    repeat (4) @(negedge clk);

    // R9 / R10: stall, then change config while a pixel is held
    ready_mode = 1;
    set_cfg(1'b1, 3'd7, 12'd100, 12'd100, 12'd100, 12'd200, 12'd200, 12'd200);
    send(12'd50, 12'd300, 12'd150, "R10 config captured at accept");
    @(negedge clk);
    set_cfg(1'b0, 3'd0, 12'd0, 12'd0, 12'd0, 12'hFFF, 12'hFFF, 12'hFFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #3;
      check(out_valid && !in_ready, "R9 stall holds valid, blocks input",
            {34'd0, out_valid, in_ready}, 36'd2);
      check({out_b, out_g, out_r} == {12'd150, 12'd200, 12'd100}, "R10 held pixel unchanged",
            {out_b, out_g, out_r}, {12'd150, 12'd200, 12'd100});
    end
    ready_mode = 0;

    repeat (50) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all pixels delivered", 36'(exp_q.size()), '0);
    finish_run();
  end

endmodule